// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives a three-phase inverter bridge. It produces three center-aligned pulse channels. Each channel has an active-low primary output and an active-low complementary output. One switching cycle lasts a programmed number of system clocks. Each channel's primary pulse is centered in the cycle and is on for a programmed number of clocks. Both edges are pulled inward by half of an even deadtime. The complementary output is released only after half of that deadtime has passed on the outer side, so a leg can never conduct on both switches.

Software loads six values through a simple write port:
- the cycle length;
- the three on-counts;
- the deadtime;
- a minimum pulse width.

Any pulse that would come out narrower than the minimum is dropped for that cycle. The three on-counts form a set: none of them is used until all three have been written. All edge positions are captured at a cycle boundary, so a cycle that is already running is never disturbed.

A one-clock sync pulse marks the first clock of every cycle. An asynchronous stop input forces all six outputs inactive (high) at once, without waiting for a clock.

Top module: `pwm3_center`

## Requirements
- R1: While `rst_n` is low, all six outputs are high and `sync_o` is low.
- R2: `sync_o` is high for exactly one clock per cycle. Its pulses are Pe clocks apart, where Pe is the programmed cycle length, raised to 2 if it is below 2. Phase k counts clocks from the sync clock, which is k = 0.
- R3: Take W as the on-count clamped to Pe, s = (Pe − W) >> 1 and e = s + W. With zero deadtime and zero minimum width, the primary output is low exactly for s ≤ k < e, and the complement is low at every other phase.
- R4: Deadtime bit 0 is ignored. With h = deadtime >> 1, the primary is low exactly for s + h ≤ k < e − h. The complement is high exactly for max(s − h, 0) ≤ k < e + h. A primary output and its complement are never low together.
- R5: If W < 2h, or W − 2h is less than the minimum-width value, the primary output stays high for the whole cycle and its complement stays low for the whole cycle.
- R6: A write to one or two of the on-counts changes no output. The new on-counts take effect together only after the third of them has been written.
- R7: New register values take effect at the first cycle boundary after they are complete. The cycle in progress keeps the edges it started with.
- R8: An on-count at or above the cycle length gives a primary output low for h ≤ k < Pe − h and a complement high for the whole cycle.
- R9: While `stop_i` is high, all six outputs are high in the same clock, with no register in the path. When `stop_i` goes low, the outputs immediately show the waveform of the current phase. The cycle counter and `sync_o` keep running during a stop.
- R10: The write select codes are: 0 = cycle length, 1/2/3 = on-count of channel A/B/C, 4 = deadtime (7 LSBs of data), 5 = minimum width (7 LSBs). A write with code 6 or 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Asynchronous stop; high forces all outputs inactive |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_sel | input | 3 | Register select code (see R10) |
| wr_data | input | 12 | Write data |
| pwm_n | output | 3 | Active-low primary outputs, bit 0 = A, 1 = B, 2 = C |
| pwmc_n | output | 3 | Active-low complementary outputs, same bit order |
| sync_o | output | 1 | One-clock pulse on the first clock of each cycle |

## Verification
On every clock, the checker enforces the stop override and the rule that a primary output and its complement are never low together. It also checks that the sync pulse is one clock wide, that the latched edge set changes only at a cycle boundary, and that arming happens only on an on-count write.

Several behaviours can be shown only by the bench's scenarios, which compare every phase of a whole cycle against an independent model:
- the exact edge positions, centering and deadtime widths;
- pulse deletion and the full-on clamp;
- partial on-count writes that must leave the outputs unchanged;
- a set written mid-cycle that must wait for the next boundary.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CNT_W  = 12;           // cycle length and on-count width
  localparam int DT_W   = 7;            // deadtime width
  localparam int PD_W   = 7;            // minimum pulse width
  localparam int NCH    = 3;            // phases
  localparam int EDGE_W = CNT_W + 2;    // room for e + h beyond the cycle
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_PERIOD = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ON0    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DEAD   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MINPW  = 3'd5;

  typedef struct packed {
    logic [EDGE_W-1:0] on_lo;   // primary active from here
    logic [EDGE_W-1:0] on_hi;   // primary inactive from here
    logic [EDGE_W-1:0] off_lo;  // complement released from here
    logic [EDGE_W-1:0] off_hi;  // complement active again from here
  } edge_t;

  function automatic logic [CNT_W-1:0] eff_period(
    input logic [CNT_W-1:0] p, input logic [CNT_W-1:0] pmin);
    return (p < pmin) ? pmin : p;
  endfunction

  // Edge placement for one channel. All-zero result means "pulse dropped".
  function automatic edge_t place_edges(
    input logic [CNT_W-1:0] p, input logic [CNT_W-1:0] w,
    input logic [DT_W-1:0] d, input logic [PD_W-1:0] pd);
    logic [EDGE_W-1:0] pe, wc, s, e, h, dd;
    edge_t r;
    pe = EDGE_W'(p);
    wc = (w >= p) ? pe : EDGE_W'(w);
    s  = (pe - wc) >> 1;
    e  = s + wc;
    h  = EDGE_W'(d[DT_W-1:1]);
    dd = h << 1;
    r  = '0;
    if (!((wc < dd) || ((wc - dd) < EDGE_W'(pd)))) begin
      r.on_lo  = s + h;
      r.on_hi  = e - h;
      r.off_lo = (s >= h) ? (s - h) : '0;
      r.off_hi = e + h;
    end
    return r;
  endfunction
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [CNT_W-1:0]          wr_data,
  output logic [CNT_W-1:0]          per_o,
  output logic [DT_W-1:0]           dt_o,
  output logic [PD_W-1:0]           pd_o,
  output logic [NCH-1:0][CNT_W-1:0] on_o,
  output logic                      arm_o
);
  logic [NCH-1:0][CNT_W-1:0] stage_q, merged;
  logic [NCH-1:0]            got_q, hit;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_hit
    assign hit[ch]    = wr_en && (wr_sel == SEL_ON0 + SEL_W'(ch));
    assign merged[ch] = hit[ch] ? wr_data : stage_q[ch];
  end

  // The set arms on the write that completes it
  assign arm_o = &(got_q | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      got_q   <= '0;
      on_o    <= '0;
      per_o   <= '0;
      dt_o    <= '0;
      pd_o    <= '0;
    end else begin
      stage_q <= merged;
      got_q   <= arm_o ? '0 : (got_q | hit);
      if (arm_o) on_o <= merged;
      if (wr_en && wr_sel == SEL_PERIOD) per_o <= wr_data;
      if (wr_en && wr_sel == SEL_DEAD)   dt_o  <= wr_data[DT_W-1:0];
      if (wr_en && wr_sel == SEL_MINPW)  pd_o  <= wr_data[PD_W-1:0];
    end
  end
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int MIN_PERIOD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] per_reg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_next_o,
  output logic             wrap_o,
  output logic             sync_o
);
  localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] per_q;

  assign per_next_o = eff_period(per_reg_i, PMIN);
  assign wrap_o     = (cnt_o >= per_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= PMIN;
      cnt_o  <= '0;
      sync_o <= 1'b0;
    end else begin
      sync_o <= (cnt_o == '0);
      if (wrap_o) begin
        cnt_o <= '0;
        per_q <= per_next_o;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel
  import pwm3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [DT_W-1:0]  dt_i,
  input  logic [PD_W-1:0]  pd_i,
  output edge_t            edges_o,
  output logic             prim_on_o,
  output logic             comp_on_o
);
  logic [EDGE_W-1:0] k;
  logic              prim_d, comp_d;

  assign k      = EDGE_W'(cnt_i);
  assign prim_d = (k >= edges_o.on_lo) && (k < edges_o.on_hi);
  assign comp_d = !((k >= edges_o.off_lo) && (k < edges_o.off_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_o   <= '0;
      prim_on_o <= 1'b0;
      comp_on_o <= 1'b0;
    end else begin
      if (wrap_i) edges_o <= place_edges(per_i, on_i, dt_i, pd_i);
      prim_on_o <= prim_d;
      comp_on_o <= comp_d;
    end
  end
endmodule

// File: rtl/pwm3_center.sv
module pwm3_center
  import pwm3_pkg::*;
#(
  parameter int MIN_PERIOD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [NCH-1:0]   pwm_n,
  output logic [NCH-1:0]   pwmc_n,
  output logic             sync_o
);
  logic [CNT_W-1:0]          per_reg, per_next, cnt;
  logic [DT_W-1:0]           dt_reg;
  logic [PD_W-1:0]           pd_reg;
  logic [NCH-1:0][CNT_W-1:0] on_set;
  logic                      arm, wrap;
  edge_t [NCH-1:0]           ch_edges;
  logic [NCH-1:0]            prim_on, comp_on;

  pwm3_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .per_o(per_reg), .dt_o(dt_reg), .pd_o(pd_reg), .on_o(on_set), .arm_o(arm)
  );

  pwm3_timebase #(.MIN_PERIOD(MIN_PERIOD)) u_tb (
    .clk(clk), .rst_n(rst_n), .per_reg_i(per_reg), .cnt_o(cnt),
    .per_next_o(per_next), .wrap_o(wrap), .sync_o(sync_o)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm3_channel u_ch (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .cnt_i(cnt), .per_i(per_next),
      .on_i(on_set[ch]), .dt_i(dt_reg), .pd_i(pd_reg),
      .edges_o(ch_edges[ch]), .prim_on_o(prim_on[ch]), .comp_on_o(comp_on[ch])
    );
  end

  // Stop acts without a register so it overrides within the same clock
  assign pwm_n  = ~prim_on | {NCH{stop_i}};
  assign pwmc_n = ~comp_on | {NCH{stop_i}};
endmodule

// File: rtl/pwm3_center_chk.sv
module pwm3_center_chk
  import pwm3_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [NCH-1:0]   pwm_n,
  input logic [NCH-1:0]   pwmc_n,
  input logic             sync_o,
  input logic             wrap,
  input logic             arm,
  input edge_t [NCH-1:0]  edges
);
  // R9
  stop_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> (&pwm_n && &pwmc_n));

  // R4
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pwm_n) & (~pwmc_n)) == '0);

  // R2
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  // R7
  edges_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(edges));

  // R6
  arm_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (wr_en && wr_sel >= SEL_ON0 && wr_sel < SEL_ON0 + SEL_W'(NCH)));
endmodule

bind pwm3_center pwm3_center_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .wr_en(wr_en), .wr_sel(wr_sel),
  .pwm_n(pwm_n), .pwmc_n(pwmc_n), .sync_o(sync_o), .wrap(wrap), .arm(arm),
  .edges(ch_edges)
);

// File: tb/pwm3_center_test.sv
`timescale 1ns/1ps
module pwm3_center_test;
  import pwm3_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             stop_i = 1'b0;
  logic             wr_en = 1'b0;
  logic [SEL_W-1:0] wr_sel = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [NCH-1:0]   pwm_n, pwmc_n;
  logic             sync_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cur [6];   // period, onA, onB, onC, deadtime, minimum width

  always #2 clk = ~clk;

  pwm3_center uut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_n(pwm_n), .pwmc_n(pwmc_n), .sync_o(sync_o)
  );

  // period, A, B, C, deadtime, min width, requirement number
  localparam int VEC [8][7] = '{
    '{20, 10,  4,  7,   0,  0, 3},  // R3 plain centering, odd slack
    '{40, 20, 30,  5,   6,  0, 4},  // R4 deadtime
    '{30, 12,  8,  3,   7,  0, 4},  // R4 odd deadtime, bit 0 ignored
    '{32, 10, 16,  7,   4,  4, 5},  // R5 channel C dropped
    '{24, 24, 30,  2,   2,  0, 8},  // R8 on-count at and above period
    '{ 1,  0,  1,  0,   0,  0, 2},  // R2 period raised to minimum
    '{50,  3, 48, 25, 126, 10, 5},  // R5 deadtime wider than every pulse
    '{60, 40, 20,  0,  10,  5, 4}   // R4 mixed
  };

  // Returns {primary active, complement active} for phase k
  function automatic bit [1:0] model(int per, int w, int d, int pd, int k);
    int pe, wc, half, first, stop_ex;
    bit gone, plow, clow;
    pe      = (per < 2) ? 2 : per;
    wc      = (w > pe) ? pe : w;
    half    = d / 2;
    first   = (pe - wc) / 2;
    stop_ex = first + wc;
    gone    = (wc < 2 * half) || (wc - 2 * half < pd);
    plow    = !gone && (k >= first + half) && (k + half < stop_ex);
    clow    = gone || (k + half < first) || (k >= stop_ex + half);
    return {plow, clow};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    wr_sel  = SEL_W'(sel);
    wr_data = CNT_W'(data);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_sync();
    @(negedge clk);
    while (sync_o !== 1'b1) @(negedge clk);
  endtask

  task automatic prog(input int p, input int a, input int b, input int c,
                      input int d, input int pd);
    wr(0, p); wr(4, d); wr(5, pd); wr(1, a); wr(2, b); wr(3, c);
    cur = '{p, a, b, c, d, pd};
    wait_sync();
    wait_sync();
  endtask

  // Compare phases k0..Pe-1 of the current cycle, then expect the next sync
  task automatic span(input string req, input int k0);
    int pe, bad, act, exp;
    string where;
    pe = (cur[0] < 2) ? 2 : cur[0];
    bad = 0; act = 0; exp = 0; where = "";
    for (int k = k0; k < pe; k++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bit [1:0]   m;
        logic [1:0] got;
        m   = model(cur[0], cur[1 + ch], cur[4], cur[5], k);
        got = {~pwm_n[ch], ~pwmc_n[ch]};
        if (got !== m) begin
          if (bad == 0) begin
            act = int'(got); exp = int'(m);
            where = $sformatf("ch%0d phase %0d {prim,comp}", ch, k);
          end
          bad++;
        end
      end
      if (sync_o !== (k == 0)) begin
        if (bad == 0) begin
          act = int'(sync_o); exp = int'(k == 0);
          where = $sformatf("sync at phase %0d", k);
        end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, req, {"waveform ", where}, act, exp);
    check(sync_o === 1'b1, req, "sync at cycle end", int'(sync_o), 1);
  endtask

  initial begin
    int pe, j, bad;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(pwm_n === 3'b111 && pwmc_n === 3'b111, "R1", "pins in reset",
          int'({pwm_n, pwmc_n}), 63);
    check(sync_o === 1'b0, "R1", "sync in reset", int'(sync_o), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      prog(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      span($sformatf("R%0d", VEC[v][6]), 0);
    end

    // R6 partial set leaves outputs as they were
    wr(1, 10); wr(2, 10);
    wait_sync(); wait_sync();
    span("R6", 0);
    wr(3, 33);
    cur[1] = 10; cur[2] = 10; cur[3] = 33;
    wait_sync(); wait_sync();
    span("R6", 0);

    // R7 set completed mid-cycle waits for the boundary
    wait_sync();
    wr(1, 50); wr(2, 5); wr(3, 17);
    span("R7", 3);
    cur[1] = 50; cur[2] = 5; cur[3] = 17;
    span("R7", 0);

    // R10 unused select codes
    wr(6, 7); wr(7, 1);
    wait_sync(); wait_sync();
    span("R10", 0);

    // R9 stop override, counter keeps running
    pe = cur[0];
    wait_sync();
    stop_i = 1'b1;
    #1;
    check(pwm_n === 3'b111 && pwmc_n === 3'b111, "R9", "pins at stop",
          int'({pwm_n, pwmc_n}), 63);
    bad = 0;
    for (int k = 1; k < pe; k++) begin
      @(negedge clk);
      if (pwm_n !== 3'b111 || pwmc_n !== 3'b111 || sync_o !== 1'b0) bad++;
    end
    check(bad == 0, "R9", "pins held high during stop", bad, 0);
    @(negedge clk);
    check(sync_o === 1'b1, "R9", "sync while stopped", int'(sync_o), 1);
    j = pe / 2;
    repeat (j) @(negedge clk);
    stop_i = 1'b0;
    #1;
    for (int ch = 0; ch < NCH; ch++) begin
      bit [1:0]   m;
      logic [1:0] got;
      m   = model(cur[0], cur[1 + ch], cur[4], cur[5], j);
      got = {~pwm_n[ch], ~pwmc_n[ch]};
      check(got === m, "R9", $sformatf("ch%0d right after release", ch),
            int'(got), int'(m));
    end
    @(negedge clk);
    span("R9", j + 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule